// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block guesses the next fetch address in the same cycle that the fetch stage presents its current program counter. It is a direct-mapped table. The table is indexed by the word-address bits just above the two byte-offset bits. Each slot has four fields:

- a valid flag
- the upper address bits of a known branch
- the address that branch jumped to
- a two-bit saturating direction counter

When the slot matches and its counter leans towards taken, the predicted next address is the stored target. In every other case the prediction is the sequential address, four bytes on.

A resolve port trains the table with one resolved branch per cycle: its address, whether it was taken, and its real target. A branch that is already in the table has its counter moved one step, and its target refreshed when it was taken. A taken branch that is not in the table claims its slot, evicting whatever was there. A not-taken branch that is not in the table leaves the table as it was. Lookup is purely combinational. Training takes effect on the clock edge, so a lookup in the same cycle sees the old contents.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every slot. After reset, every lookup reports no hit and not taken, and predicts the fetch address plus 4.
- R2: The slot index is fetchPc[IDX_W+1:2], with IDX_W = log2(ENTRIES). A lookup hits only when the indexed slot is valid and its stored upper bits equal fetchPc[PC_W-1:IDX_W+2]. Two addresses that share an index but differ above it never both hit at once.
- R3: predTaken is high exactly when the lookup hits and the counter's upper bit is 1. predNextPc is the stored target when predTaken is high, and fetchPc+4 (modulo 2^PC_W) otherwise.
- R4: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A resolved hit moves the counter one code up when the branch was taken and one code down when it was not. The counter holds at 11 and at 00.
- R5: A taken resolution that misses writes the indexed slot with the branch's upper bits and target, marks it valid, and starts its counter at 10.
- R6: A not-taken resolution that misses changes nothing: the slot keeps its old occupant, or stays empty.
- R7: A taken resolution that hits replaces the stored target with the resolved one. A not-taken resolution that hits keeps the stored target.
- R8: When a lookup and a resolution touch the same slot in the same cycle, the lookup outputs reflect the contents before that resolution.
- R9: The lookup outputs depend only on fetchPc and the table state in the same cycle. No register lies between fetchPc and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | PC_W | Address being fetched this cycle |
| predNextPc | output | PC_W | Predicted next fetch address |
| predHit | output | 1 | Lookup matched a valid slot |
| predTaken | output | 1 | Lookup hit and the counter leans towards taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction (1 = taken) |
| updTarget | input | PC_W | Resolved target address |

## Verification
The bench walks one branch through every counter code, in both directions and into both saturation ends. A counter that wraps would flip a strongly-taken branch to not-taken, and one that skipped the weak codes would redirect one resolution too early or too late.

It places a second branch in the same slot, first as a not-taken miss and then as a taken miss. A design that allocates on any miss would evict the first branch too early. A design that compared only index bits would report a hit for the alias.

It looks up the branch in the very cycle it is first allocated, and expects a miss. A design that forwarded the write would redirect one cycle early. A long random phase over a few colliding addresses then compares all three outputs against the reference model on every cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Counter codes: MSB is the predicted direction.
  localparam logic [1:0] CTR_STRONG_NT = 2'b00;
  localparam logic [1:0] CTR_WEAK_T    = 2'b10;
  localparam logic [1:0] CTR_STRONG_T  = 2'b11;

  // Write strobes from control to datapath for the slot addressed by updPc.
  typedef struct packed {
    logic       alloc;     // claim slot: set valid, write tag
    logic       wrTarget;  // write target field
    logic       wrCtr;     // write counter field
    logic [1:0] ctrNext;   // counter value to write
  } btbStrobe_t;

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updHit,
  input  logic [1:0] updCtr,
  output btbStrobe_t strobe
);

  logic [1:0] ctrStepped;

  // Saturating one-step move of the direction counter.
  always_comb begin
    if (updTaken) begin
      ctrStepped = (updCtr == CTR_STRONG_T) ? CTR_STRONG_T : updCtr + 2'd1;
    end else begin
      ctrStepped = (updCtr == CTR_STRONG_NT) ? CTR_STRONG_NT : updCtr - 2'd1;
    end
  end

  always_comb begin
    strobe = '0;
    if (updValid) begin
      if (updHit) begin
        strobe.wrCtr    = 1'b1;
        strobe.ctrNext  = ctrStepped;
        strobe.wrTarget = updTaken;
      end else if (updTaken) begin
        strobe.alloc    = 1'b1;
        strobe.wrTarget = 1'b1;
        strobe.wrCtr    = 1'b1;
        strobe.ctrNext  = CTR_WEAK_T;
      end
    end
  end

endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] predNextPc,
  output logic            predHit,
  output logic            predTaken,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  btbStrobe_t      strobe,
  output logic            updHit,
  output logic [1:0]      updCtr
);

  localparam int OFS_W = 2;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic             validQ  [ENTRIES];
  logic [TAG_W-1:0] tagQ    [ENTRIES];
  logic [PC_W-1:0]  targetQ [ENTRIES];
  logic [1:0]       ctrQ    [ENTRIES];

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;
  logic             unusedUpdLow;

  assign lookIdx      = fetchPc[OFS_W +: IDX_W];
  assign lookTag      = fetchPc[PC_W-1 -: TAG_W];
  assign updIdx       = updPc[OFS_W +: IDX_W];
  assign updTag       = updPc[PC_W-1 -: TAG_W];
  assign unusedUpdLow = ^updPc[OFS_W-1:0];

  // Lookup side: combinational read of the pre-update contents.
  always_comb begin
    predHit    = validQ[lookIdx] && (tagQ[lookIdx] == lookTag);
    predTaken  = predHit && ctrQ[lookIdx][1];
    predNextPc = predTaken ? targetQ[lookIdx] : fetchPc + PC_W'(4);
  end

  // Resolve side: match status for the control.
  assign updHit = validQ[updIdx] && (tagQ[updIdx] == updTag);
  assign updCtr = ctrQ[updIdx];

  // One write port, decoded per slot.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = (updIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[e] <= 1'b0;
      end else if (sel && strobe.alloc) begin
        validQ[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && strobe.alloc)    tagQ[e]    <= updTag;
      if (sel && strobe.wrTarget) targetQ[e] <= updTarget;
      if (sel && strobe.wrCtr)    ctrQ[e]    <= strobe.ctrNext;
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] predNextPc,
  output logic            predHit,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget
);

  btbStrobe_t strobe;
  logic       updHit;
  logic [1:0] updCtr;

  btb_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updHit   (updHit),
    .updCtr   (updCtr),
    .strobe   (strobe)
  );

  btb_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .fetchPc    (fetchPc),
    .predNextPc (predNextPc),
    .predHit    (predHit),
    .predTaken  (predTaken),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .strobe     (strobe),
    .updHit     (updHit),
    .updCtr     (updCtr)
  );

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] predNextPc,
  input logic            predHit,
  input logic            predTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic [PC_W-1:0] updTarget
);

  // R1: first cycle out of reset sees an empty table.
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predHit);

  // R3: a taken prediction needs a hit.
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    predTaken |-> predHit);

  // R3: without a taken prediction the next address is sequential.
  p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4));

  // R5 / R7: after a taken resolution the branch is present, and redirects to the new target.
  p_taken_trains_r5: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken) |=>
      ((fetchPc == $past(updPc)) |->
        (predHit && (!predTaken || predNextPc == $past(updTarget)))));

  // R6: a not-taken miss does not make the branch start hitting.
  p_nt_miss_no_alloc_r6: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken && fetchPc == updPc && !predHit) |=>
      ((fetchPc == $past(updPc)) |-> !predHit));

endmodule

bind btb_predictor btb_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetchPc    (fetchPc),
  .predNextPc (predNextPc),
  .predHit    (predHit),
  .predTaken  (predTaken),
  .updValid   (updValid),
  .updPc      (updPc),
  .updTaken   (updTaken),
  .updTarget  (updTarget)
);

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;

  localparam int PC_W    = 32;
  localparam int ENTRIES = 16;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] fetchPc;
  logic [PC_W-1:0] predNextPc;
  logic            predHit;
  logic            predTaken;
  logic            updValid;
  logic [PC_W-1:0] updPc;
  logic            updTaken;
  logic [PC_W-1:0] updTarget;

  always #2 clk = ~clk;  // 250 MHz

  btb_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dut (
    .clk (clk), .rst (rst), .fetchPc (fetchPc), .predNextPc (predNextPc),
    .predHit (predHit), .predTaken (predTaken), .updValid (updValid),
    .updPc (updPc), .updTaken (updTaken), .updTarget (updTarget)
  );

  // Behavioural reference: slot number -> stored branch word address, target, counter.
  int unsigned mWord   [int];
  int unsigned mTarget [int];
  int          mCtr    [int];

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  function automatic int slotOf(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % ENTRIES);
  endfunction

  function automatic bit refHit(logic [PC_W-1:0] pc);
    int s = slotOf(pc);
    return mWord.exists(s) && (mWord[s] == int'(pc >> 2));
  endfunction

  task automatic refUpdate(logic [PC_W-1:0] pc, bit taken, logic [PC_W-1:0] tgt);
    int s = slotOf(pc);
    if (refHit(pc)) begin
      if (taken) begin
        mCtr[s] = (mCtr[s] < 3) ? mCtr[s] + 1 : 3;
        mTarget[s] = tgt;
      end else begin
        mCtr[s] = (mCtr[s] > 0) ? mCtr[s] - 1 : 0;
      end
    end else if (taken) begin
      mWord[s]   = int'(pc >> 2);
      mTarget[s] = tgt;
      mCtr[s]    = 2;
    end
  endtask

  // One cycle: drive, compare outputs against the pre-update model, then train the model.
  task automatic step(string req, logic [PC_W-1:0] fpc,
                      bit uv, logic [PC_W-1:0] upc, bit ut, logic [PC_W-1:0] utgt);
    bit eHit, eTaken;
    logic [PC_W-1:0] eNext;
    @(negedge clk);
    fetchPc = fpc; updValid = uv; updPc = upc; updTaken = ut; updTarget = utgt;
    #1;
    eHit   = refHit(fpc);
    eTaken = eHit && (mCtr[slotOf(fpc)] >= 2);
    eNext  = eTaken ? mTarget[slotOf(fpc)] : fpc + 32'd4;
    compared++;
    if (predHit !== eHit || predTaken !== eTaken || predNextPc !== eNext) begin
      mismatched++;
      $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h, expected hit=%b taken=%b next=%h",
               req, fpc, predHit, predTaken, predNextPc, eHit, eTaken, eNext);
    end
    @(posedge clk);
    if (uv) refUpdate(upc, ut, utgt);
  endtask

  localparam logic [PC_W-1:0] PC_A = 32'h0000_1000;
  localparam logic [PC_W-1:0] PC_B = 32'h0000_1040;  // same slot as PC_A, different upper bits

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    rst = 1'b1; fetchPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0; updTarget = '0;
    // A taken update during reset must not survive it.
    @(negedge clk); updValid = 1'b1; updPc = PC_A; updTaken = 1'b1; updTarget = 32'h9000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; updValid = 1'b0;

    // R1: empty after reset
    step("R1", PC_A, 0, '0, 0, '0);
    step("R1", 32'h0000_2008, 0, '0, 0, '0);
    // R9: outputs track fetchPc within the cycle
    step("R9", 32'hFFFF_FFFC, 0, '0, 0, '0);
    // R5 + R8: allocate A; same-cycle lookup sees the old (empty) slot
    step("R8", PC_A, 1, PC_A, 1, 32'h0000_2000);
    step("R5", PC_A, 0, '0, 0, '0);
    step("R2", PC_A + 32'd4, 0, '0, 0, '0);
    // R4: walk down through every code and saturate at 00
    step("R4", PC_A, 1, PC_A, 0, 32'h0);   // 10 -> 01
    step("R4", PC_A, 1, PC_A, 0, 32'h0);   // 01 -> 00
    step("R4", PC_A, 1, PC_A, 0, 32'h0);   // 00 holds
    step("R4", PC_A, 0, '0, 0, '0);
    // R4: walk up and saturate at 11; R7 refreshes target
    step("R4", PC_A, 1, PC_A, 1, 32'h0000_2000);  // 00 -> 01
    step("R4", PC_A, 1, PC_A, 1, 32'h0000_2000);  // 01 -> 10
    step("R4", PC_A, 1, PC_A, 1, 32'h0000_2000);  // 10 -> 11
    step("R7", PC_A, 1, PC_A, 1, 32'h0000_3000);  // 11 holds, new target
    step("R7", PC_A, 1, PC_A, 0, 32'h0000_5000);  // 11 -> 10, target kept
    step("R7", PC_A, 0, '0, 0, '0);
    // R6: not-taken alias miss leaves A in place
    step("R6", PC_B, 1, PC_B, 0, 32'h0000_4000);
    step("R6", PC_A, 0, '0, 0, '0);
    step("R2", PC_B, 0, '0, 0, '0);
    // R5: taken alias evicts A
    step("R5", PC_B, 1, PC_B, 1, 32'h0000_4000);
    step("R5", PC_B, 0, '0, 0, '0);
    step("R2", PC_A, 0, '0, 0, '0);
    // R3: address wrap on the sequential path
    step("R3", 32'hFFFF_FFFC, 0, '0, 0, '0);

    // Random mix over a few colliding addresses
    for (int i = 0; i < 400; i++) begin
      logic [PC_W-1:0] fpc, upc, tgt;
      fpc = 32'h1000 + (32'($urandom_range(0, 5)) << 2) + (32'($urandom_range(0, 1)) << 6);
      upc = 32'h1000 + (32'($urandom_range(0, 5)) << 2) + (32'($urandom_range(0, 1)) << 6);
      tgt = 32'h8000 + (32'($urandom_range(0, 255)) << 2);
      step("R3", fpc, bit'($urandom_range(0, 1)), upc, bit'($urandom_range(0, 1)), tgt);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule